// File: doc/BRIEF.md
# PCI Interrupt Routing Autodetector

This block decides how the four interrupt pins (INTA..INTD) of the PCI slots are routed onto four system interrupt lines. Some system software expects an old, incorrect routing. Other software expects the correct slot-swizzled routing. The block tells the two apart by watching configuration-space writes to the interrupt-line register. The first write that reveals what the software expects fixes the routing mode until the next reset.

A routing function maps a slot number and a pin number onto an output line index. It is purely combinational from the registered mode. A strap selects the board variant. The alternate variant has a different swizzle offset, never runs detection, and always routes correctly. The reset-time mode input lets an integrator force a mode when the software is already known.

Top module: `irq_rt_autodetect`

## Requirements
- R1: While `rst_ni` is low, `mode_o` loads from `rst_mode_i`: 0 gives provisional, 1 gives legacy, 2 gives corrected, and code 3 gives provisional.
- R2: `mode_o` encodes provisional as 0, legacy as 1 and corrected as 2. It never shows 3.
- R3: A write is qualifying only when all of these hold: `cfg_wr_i` is high, `cfg_addr_i[7:0]` equals `LINE_OFS` (default 0x3C), the mode is provisional, and `alt_variant_i` is 0. The mode takes its classified value at that clock edge and is visible from the next cycle.
- R4: The slot modulo 4 is `cfg_addr_i[12:11]`, the low bits of the device field `cfg_addr_i[15:11]`. For a write value of 27, the mode stays provisional when the slot modulo 4 is 2, and becomes legacy otherwise.
- R5: A write value equal to 27 + slot mod 4, or to 91 + slot mod 4, gives legacy.
- R6: Any other write value gives corrected.
- R7: Once the mode is legacy or corrected, no write changes it until reset.
- R8: While `alt_variant_i` is 1, writes never change the mode.
- R9: On the primary variant in legacy mode, `route_o` equals `pin_i` (pin 0..3 = INTA..INTD).
- R10: On the primary variant in provisional or corrected mode, `route_o` = (`slot_i` + `pin_i` + 2) mod 4.
- R11: On the alternate variant, `route_o` = (`slot_i` + `pin_i` + 3) mod 4, in every mode.
- R12: Writes to any other register offset leave the mode unchanged.
- R13: Changing `rst_mode_i` after reset has been released has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 16 | Configuration address: devfn in [15:8], register offset in [7:0] |
| cfg_wdata_i | input | 8 | Data byte of the configuration write |
| alt_variant_i | input | 1 | Board variant strap; 1 selects the alternate variant |
| rst_mode_i | input | 2 | Mode loaded during reset |
| slot_i | input | 5 | Slot number to route |
| pin_i | input | 2 | Interrupt pin to route, 0..3 = INTA..INTD |
| mode_o | output | 2 | Current routing mode |
| route_o | output | 2 | System interrupt line index for slot_i/pin_i |

## Verification
The bench targets the following cases and how a wrong design would fail each:
- Value 27 written from a slot whose modulo is 2. A design that drops this exception would fall into legacy mode when it should stay provisional.
- A second telling write after the first. A design that is not sticky would flip to the mode the later write implies.
- Writes to neighbouring offsets, and writes made while the alternate strap is set. A loose address decode or a missing variant gate would change the mode on these.
- Routing in each mode on both variants, plus reset code 3 and a reset input that changes after release. A wrong swizzle constant, or a mode that keeps tracking the reset input, shows up directly on `route_o` or `mode_o`.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  typedef enum logic [1:0] {
    MODE_PROV   = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_FIXED  = 2'd2
  } rt_mode_e;

  function automatic rt_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd1:    decode_mode = MODE_LEGACY;
      2'd2:    decode_mode = MODE_FIXED;
      default: decode_mode = MODE_PROV;
    endcase
  endfunction
endpackage

// File: rtl/irq_rt_classify.sv
module irq_rt_classify
  import irq_rt_pkg::*;
#(
  parameter int LEGACY_BASE = 27,
  parameter int HIGH_SHIFT  = 64,
  parameter int DATA_W      = 8,
  parameter int SLOT_MOD_W  = 2
) (
  input  logic [SLOT_MOD_W-1:0] slot_mod_i,
  input  logic [DATA_W-1:0]     data_i,
  output rt_mode_e              cls_o
);
  localparam logic [DATA_W-1:0] BASE_V = DATA_W'(LEGACY_BASE);
  localparam logic [DATA_W-1:0] HIGH_V = DATA_W'(LEGACY_BASE + HIGH_SHIFT);
  localparam logic [SLOT_MOD_W-1:0] SHARED_SLOT = SLOT_MOD_W'(2);

  logic [DATA_W-1:0] swz_lo, swz_hi;

  always_comb begin
    swz_lo = BASE_V + DATA_W'(slot_mod_i);
    swz_hi = HIGH_V + DATA_W'(slot_mod_i);
    if (data_i == BASE_V)
      cls_o = (slot_mod_i == SHARED_SLOT) ? MODE_PROV : MODE_LEGACY;
    else if (data_i == swz_lo || data_i == swz_hi)
      cls_o = MODE_LEGACY;
    else
      cls_o = MODE_FIXED;
  end
endmodule

// File: rtl/irq_rt_mode_reg.sv
module irq_rt_mode_reg
  import irq_rt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rt_mode_e init_i,
  input  logic     upd_i,
  input  rt_mode_e cls_i,
  output rt_mode_e mode_o
);
  rt_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (upd_i && mode_q == MODE_PROV) mode_d = cls_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= init_i;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/irq_rt_map.sv
module irq_rt_map
  import irq_rt_pkg::*;
#(
  parameter int SLOT_W   = 5,
  parameter int LINE_W   = 2,
  parameter int PRI_OFS  = 2,
  parameter int ALT_OFS  = 3
) (
  input  rt_mode_e          mode_i,
  input  logic              alt_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [LINE_W-1:0] pin_i,
  output logic [LINE_W-1:0] route_o
);
  logic [LINE_W-1:0] ofs;

  always_comb begin
    ofs = alt_i ? LINE_W'(ALT_OFS) : LINE_W'(PRI_OFS);
    if (!alt_i && mode_i == MODE_LEGACY)
      route_o = pin_i;
    else
      route_o = slot_i[LINE_W-1:0] + pin_i + ofs;
  end
endmodule

// File: rtl/irq_rt_autodetect.sv
module irq_rt_autodetect
  import irq_rt_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          SLOT_W      = 5,
  parameter int          NUM_LINES   = 4,
  parameter logic [7:0]  LINE_OFS    = 8'h3C,
  parameter int          LEGACY_BASE = 27,
  parameter int          HIGH_SHIFT  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              alt_variant_i,
  input  logic [1:0]        rst_mode_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [1:0]        pin_i,
  output logic [1:0]        mode_o,
  output logic [1:0]        route_o
);
  localparam int LINE_W  = $clog2(NUM_LINES);
  localparam int DEV_LSB = 11;

  rt_mode_e mode, cls, init_mode;
  logic     upd;

  assign init_mode = decode_mode(rst_mode_i);
  assign upd = cfg_wr_i && (cfg_addr_i[7:0] == LINE_OFS) && !alt_variant_i;

  irq_rt_classify #(
    .LEGACY_BASE(LEGACY_BASE), .HIGH_SHIFT(HIGH_SHIFT),
    .DATA_W(DATA_W), .SLOT_MOD_W(LINE_W)
  ) u_cls (
    .slot_mod_i(cfg_addr_i[DEV_LSB +: LINE_W]),
    .data_i    (cfg_wdata_i),
    .cls_o     (cls)
  );

  irq_rt_mode_reg u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(init_mode),
    .upd_i (upd),
    .cls_i (cls),
    .mode_o(mode)
  );

  irq_rt_map #(.SLOT_W(SLOT_W), .LINE_W(LINE_W)) u_map (
    .mode_i (mode),
    .alt_i  (alt_variant_i),
    .slot_i (slot_i),
    .pin_i  (pin_i),
    .route_o(route_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/irq_rt_checker.sv
module irq_rt_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_wr_i,
  input logic [15:0] cfg_addr_i,
  input logic        alt_variant_i,
  input logic [4:0]  slot_i,
  input logic [1:0]  pin_i,
  input logic [1:0]  mode_o,
  input logic [1:0]  route_o
);
  a_r2_valid_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0) |=> $stable(mode_o));

  a_r12_other_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_wr_i && cfg_addr_i[7:0] == 8'h3C) |=> $stable(mode_o));

  a_r8_alt_no_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_variant_i |=> $stable(mode_o));

  a_r9_legacy_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alt_variant_i && mode_o == 2'd1) |-> route_o == pin_i);

  a_r11_alt_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_variant_i |-> route_o == 2'(slot_i[1:0] + pin_i + 2'd3));
endmodule

bind irq_rt_autodetect irq_rt_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_wr_i     (cfg_wr_i),
  .cfg_addr_i   (cfg_addr_i),
  .alt_variant_i(alt_variant_i),
  .slot_i       (slot_i),
  .pin_i        (pin_i),
  .mode_o       (mode_o),
  .route_o      (route_o)
);

// File: tb/tb_irq_rt_autodetect.sv
module tb_irq_rt_autodetect;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [15:0] cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        alt_variant_i = 1'b0;
  logic [1:0]  rst_mode_i = 2'd0;
  logic [4:0]  slot_i = '0;
  logic [1:0]  pin_i = '0;
  logic [1:0]  mode_o, route_o;

  int checks = 0;
  int failures = 0;
  int exp_mode = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_rt_autodetect dut (.*);

  function automatic int ref_class(int s, int d);
    if (d == 27) return (s == 2) ? 0 : 1;
    if (d == 27 + s || d == 91 + s) return 1;
    return 2;
  endfunction

  function automatic int ref_route(int m, bit alt, int slot, int pin);
    if (alt) return (slot + pin + 3) % 4;
    if (m == 1) return pin;
    return (slot + pin + 2) % 4;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] code, input string req);
    @(negedge clk_i);
    rst_mode_i = code;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    exp_mode = (code == 2'd3) ? 0 : int'(code);
    #1 check(req, mode_o, exp_mode);
  endtask

  // one write cycle, mode checked in the following cycle
  task automatic do_write(input int dev, input logic [7:0] ofs, input int data,
                          input bit alt, input string req);
    @(negedge clk_i);
    cfg_addr_i = {dev[4:0], 3'd0, ofs};
    cfg_wdata_i = data[7:0];
    alt_variant_i = alt;
    cfg_wr_i = 1'b1;
    if (exp_mode == 0 && !alt && ofs == 8'h3C) exp_mode = ref_class(dev % 4, data);
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
    #1 check(req, mode_o, exp_mode);
  endtask

  task automatic chk_route(input int slot, input int pin, input string req);
    slot_i = slot[4:0];
    pin_i = pin[1:0];
    #1 check(req, route_o, ref_route(exp_mode, alt_variant_i, slot, pin));
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    do_reset(2'd0, "R1");
    do_write(2, 8'h3C, 27, 0, "R4");
    do_write(1, 8'h3D, 50, 0, "R12");
    do_write(0, 8'h3B, 91, 0, "R12");
    for (int p = 0; p < 4; p++) chk_route(7, p, "R10");
    do_write(5, 8'h3C, 28, 0, "R5");
    check("R2", mode_o, 1);
    do_write(5, 8'h3C, 99, 0, "R7");
    for (int p = 0; p < 4; p++) chk_route(9, p, "R9");

    do_reset(2'd0, "R1");
    do_write(0, 8'h3C, 50, 1, "R8");
    for (int p = 0; p < 4; p++) chk_route(2, p, "R11");
    do_write(0, 8'h3C, 50, 0, "R6");
    do_write(3, 8'h3C, 27, 0, "R7");
    for (int p = 0; p < 4; p++) chk_route(3, p, "R10");

    do_reset(2'd0, "R1");
    do_write(3, 8'h3C, 27, 0, "R4");
    do_reset(2'd0, "R1");
    do_write(6, 8'h3C, 93, 0, "R5");

    do_reset(2'd3, "R1");
    do_reset(2'd1, "R1");
    alt_variant_i = 1'b1;
    chk_route(1, 2, "R11");
    alt_variant_i = 1'b0;
    rst_mode_i = 2'd2;
    repeat (3) @(negedge clk_i);
    #1 check("R13", mode_o, 1);
    do_reset(2'd2, "R1");

    for (int i = 0; i < 3000; i++) begin
      int dev, data, sel;
      bit alt;
      logic [7:0] ofs;
      if ($urandom_range(0, 15) == 0) do_reset(2'($urandom_range(0, 3)), "R1");
      dev = $urandom_range(0, 31);
      alt = ($urandom_range(0, 9) == 0);
      ofs = ($urandom_range(0, 1) == 0) ? 8'h3C : 8'($urandom_range(0, 255));
      sel = $urandom_range(0, 3);
      case (sel)
        0: data = 27;
        1: data = 27 + dev % 4;
        2: data = 91 + dev % 4;
        default: data = $urandom_range(0, 255);
      endcase
      do_write(dev, ofs, data, alt, "R3");
      chk_route($urandom_range(0, 31), $urandom_range(0, 3),
                alt ? "R11" : (exp_mode == 1 ? "R9" : "R10"));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule